// File: doc/BRIEF.md
# PTP Event Timestamp Matcher with Aging

This block keeps a small table of captured event timestamp records. Each record holds a hardware tag code, a seconds count, a nanoseconds count, and the clock identity, port number and sequence ID of the PTP message that produced it. Packet-handling logic parses the header of a received or transmitted PTP message and presents a lookup with the message type, clock identity, port number, sequence ID and a version-1 flag. The block scans the table and replies with a hit flag and the combined nanosecond time of the matching record. A record that answers a lookup is released for reuse.

A free-running tick strobe advances an internal age counter. Every record carries a deadline set at insertion. A record whose deadline has passed is released when a scan meets it, whether or not that scan hits. Inserts come through a single-cycle valid strobe. An insert that finds every slot occupied is dropped and raises an error pulse. Lookups use a valid/ready request and a valid/ready response, and only one lookup is in flight at a time.

Top module: `ptm_matcher`

## Requirements
- R1: After reset, `lk_ready_o` is 1, `rsp_valid_o` and `ins_err_o` are 0, and the table is empty, so any lookup misses.
- R2: The 3-bit record tag code is translated before comparison. Code 1 becomes message type 0, code 4 becomes type 1, code 2 becomes type 2 and code 3 becomes type 3. Codes 0, 5, 6 and 7 become 4'hF, which never matches, even against a lookup type of 4'hF.
- R3: A lookup hits only when the translated type, the clock identity, the port number and the sequence ID all equal the lookup fields. A difference in any one of them gives a miss.
- R4: A lookup with `lk_v1_i` = 1 always misses and releases no matching record.
- R5: On a hit, `rsp_hit_o` = 1 and `rsp_ns_o` = seconds × 1,000,000,000 + nanoseconds. The record is released, so an identical second lookup misses.
- R6: On a miss, `rsp_hit_o` = 0 and `rsp_ns_o` = 0.
- R7: A record inserted at tick count T still matches while the tick count is T + AGE_TICKS. From T + AGE_TICKS + 1 onward it is expired, never matches, and is released by the next scan so that its slot accepts a new insert.
- R8: The table holds DEPTH records. An insert while all DEPTH are held is dropped, `ins_err_o` is 1 for the single cycle after that insert, and the dropped record never matches.
- R9: When several live records match, the one inserted earliest answers first.
- R10: A lookup is taken on a clock edge with `lk_valid_i` and `lk_ready_o` both high. `lk_ready_o` stays 0 from that edge until the response is taken. `rsp_valid_o` rises DEPTH + 2 edges after the taking edge. `rsp_hit_o` and `rsp_ns_o` hold steady until `rsp_ready_i` takes the response.
- R11: A record inserted on or after the edge that takes a lookup is not visible to that lookup.
- R12: Expiry stays correct when the tick counter wraps around, because it compares the tick count and the deadline by the sign of their modular difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Age counter strobe, one count per high cycle |
| ins_valid_i | input | 1 | Insert strobe |
| ins_code_i | input | 3 | Record tag code |
| ins_sec_i | input | SEC_W | Record seconds |
| ins_nsec_i | input | NSEC_W | Record nanoseconds |
| ins_clkid_i | input | ID_W | Record clock identity |
| ins_port_i | input | PORT_W | Record port number |
| ins_seq_i | input | SEQ_W | Record sequence ID |
| ins_err_o | output | 1 | Insert dropped because the table was full |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_ready_o | output | 1 | Lookup request can be taken |
| lk_v1_i | input | 1 | Lookup belongs to a PTP version 1 message |
| lk_type_i | input | 4 | Lookup message type |
| lk_clkid_i | input | ID_W | Lookup clock identity |
| lk_port_i | input | PORT_W | Lookup port number |
| lk_seq_i | input | SEQ_W | Lookup sequence ID |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_hit_o | output | 1 | A matching record was found |
| rsp_ns_o | output | 64 | Combined nanosecond time, 0 on a miss |

## Verification
The bench builds the block with DEPTH = 8, AGE_TICKS = 5, TICK_W = 8 and SER_W = 8. An eight-slot table can be filled within a few cycles, so the dropped insert and the release of expired slots come into reach. A five-tick age window puts the boundary between the last matching tick and the first expired tick a few strobes apart. An eight-bit tick counter wraps after 256 strobes, which lets the bench place a record's deadline on the far side of the wrap. Each lookup takes ten cycles, so an insert can be placed inside a running scan.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SCAN,
    S_DRAIN,
    S_CALC,
    S_RESP
  } ptm_state_e;

  localparam logic [3:0] TYPE_NONE = 4'hF;

  // translate a record tag code into the PTP message-type encoding
  function automatic logic [3:0] code_to_type(input logic [2:0] code);
    case (code)
      3'd1:    code_to_type = 4'd0;
      3'd2:    code_to_type = 4'd2;
      3'd3:    code_to_type = 4'd3;
      3'd4:    code_to_type = 4'd1;
      default: code_to_type = TYPE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ptm_store.sv
// Record memory: one write port, one synchronous read port (block RAM style)
module ptm_store #(
  parameter int DEPTH = 100,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/ptm_free_pick.sv
// Picks the lowest unoccupied slot and reports when none is left
module ptm_free_pick #(
  parameter int DEPTH = 100,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] live,
  output logic [AW-1:0]    free_idx,
  output logic             full
);
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!live[i]) free_idx = AW'(i);
    end
    full = &live;
  end
endmodule

// File: rtl/ptm_cmp.sv
// Per-record decision: eligible for this scan, expired, matching
module ptm_cmp
  import ptm_pkg::*;
#(
  parameter int TICK_W = 16,
  parameter int SER_W  = 16,
  parameter int ID_W   = 64,
  parameter int PORT_W = 16,
  parameter int SEQ_W  = 16
) (
  input  logic              slot_live,
  input  logic [SER_W-1:0]  rec_ser,
  input  logic [TICK_W-1:0] rec_dl,
  input  logic [2:0]        rec_code,
  input  logic [ID_W-1:0]   rec_clkid,
  input  logic [PORT_W-1:0] rec_port,
  input  logic [SEQ_W-1:0]  rec_seq,
  input  logic [SER_W-1:0]  lim,
  input  logic [TICK_W-1:0] now,
  input  logic              key_v1,
  input  logic [3:0]        key_type,
  input  logic [ID_W-1:0]   key_clkid,
  input  logic [PORT_W-1:0] key_port,
  input  logic [SEQ_W-1:0]  key_seq,
  output logic              elig,
  output logic              expired,
  output logic              match
);
  logic [SER_W-1:0]  ser_d;
  logic [TICK_W-1:0] age_d;
  logic [3:0]        rec_type;

  always_comb begin
    ser_d    = rec_ser - lim;
    age_d    = now - rec_dl;
    rec_type = code_to_type(rec_code);
    // inserted strictly before the scan snapshot
    elig     = slot_live && ser_d[SER_W-1];
    // now after deadline: modular difference positive
    expired  = elig && !age_d[TICK_W-1] && (age_d != '0);
    match    = elig && !expired && !key_v1 &&
               (rec_type != TYPE_NONE) && (rec_type == key_type) &&
               (rec_clkid == key_clkid) && (rec_port == key_port) &&
               (rec_seq == key_seq);
  end
endmodule

// File: rtl/ptm_matcher.sv
module ptm_matcher
  import ptm_pkg::*;
#(
  parameter int DEPTH     = 100,
  parameter int TICK_W    = 16,
  parameter int AGE_TICKS = 1000,
  parameter int SER_W     = 16,
  parameter int SEC_W     = 48,
  parameter int NSEC_W    = 30,
  parameter int ID_W      = 64,
  parameter int PORT_W    = 16,
  parameter int SEQ_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              ins_valid_i,
  input  logic [2:0]        ins_code_i,
  input  logic [SEC_W-1:0]  ins_sec_i,
  input  logic [NSEC_W-1:0] ins_nsec_i,
  input  logic [ID_W-1:0]   ins_clkid_i,
  input  logic [PORT_W-1:0] ins_port_i,
  input  logic [SEQ_W-1:0]  ins_seq_i,
  output logic              ins_err_o,
  input  logic              lk_valid_i,
  output logic              lk_ready_o,
  input  logic              lk_v1_i,
  input  logic [3:0]        lk_type_i,
  input  logic [ID_W-1:0]   lk_clkid_i,
  input  logic [PORT_W-1:0] lk_port_i,
  input  logic [SEQ_W-1:0]  lk_seq_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_hit_o,
  output logic [63:0]       rsp_ns_o
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int REC_W = SER_W + TICK_W + 3 + SEC_W + NSEC_W + ID_W + PORT_W + SEQ_W;
  localparam logic [63:0] NS_PER_S = 64'd1000000000;

  ptm_state_e state;
  logic [AW-1:0]     idx;
  logic [DEPTH-1:0]  live;
  logic [TICK_W-1:0] now_q;
  logic [SER_W-1:0]  ser_ctr, lim;
  logic              key_v1;
  logic [3:0]        key_type;
  logic [ID_W-1:0]   key_clkid;
  logic [PORT_W-1:0] key_port;
  logic [SEQ_W-1:0]  key_seq;
  logic              p1_go, p1_live;
  logic [AW-1:0]     p1_idx;
  logic              best_found;
  logic [AW-1:0]     best_idx;
  logic [SER_W-1:0]  best_ser;
  logic [SEC_W-1:0]  best_sec;
  logic [NSEC_W-1:0] best_nsec;

  // insert path
  logic [AW-1:0]    free_idx;
  logic             full, ins_ok;
  logic [REC_W-1:0] wr_rec, rd_rec;

  ptm_free_pick #(.DEPTH(DEPTH)) u_pick (
    .live(live), .free_idx(free_idx), .full(full)
  );

  assign ins_ok = ins_valid_i && !full;
  assign wr_rec = {ser_ctr, now_q + TICK_W'(AGE_TICKS), ins_code_i, ins_sec_i,
                   ins_nsec_i, ins_clkid_i, ins_port_i, ins_seq_i};

  ptm_store #(.DEPTH(DEPTH), .W(REC_W)) u_store (
    .clk(clk), .we(ins_ok), .wa(free_idx), .wd(wr_rec),
    .ra(idx), .rd(rd_rec)
  );

  // scan path, second stage
  logic [SER_W-1:0]  r_ser;
  logic [TICK_W-1:0] r_dl;
  logic [2:0]        r_code;
  logic [SEC_W-1:0]  r_sec;
  logic [NSEC_W-1:0] r_nsec;
  logic [ID_W-1:0]   r_clkid;
  logic [PORT_W-1:0] r_port;
  logic [SEQ_W-1:0]  r_seq;
  logic              c_elig, c_exp, c_match;
  logic [SER_W-1:0]  older_d;
  logic              take_best;
  logic [63:0]       prod;

  assign {r_ser, r_dl, r_code, r_sec, r_nsec, r_clkid, r_port, r_seq} = rd_rec;

  ptm_cmp #(
    .TICK_W(TICK_W), .SER_W(SER_W), .ID_W(ID_W), .PORT_W(PORT_W), .SEQ_W(SEQ_W)
  ) u_cmp (
    .slot_live(p1_live), .rec_ser(r_ser), .rec_dl(r_dl), .rec_code(r_code),
    .rec_clkid(r_clkid), .rec_port(r_port), .rec_seq(r_seq),
    .lim(lim), .now(now_q), .key_v1(key_v1), .key_type(key_type),
    .key_clkid(key_clkid), .key_port(key_port), .key_seq(key_seq),
    .elig(c_elig), .expired(c_exp), .match(c_match)
  );

  assign older_d   = r_ser - best_ser;
  assign take_best = p1_go && c_match && (!best_found || older_d[SER_W-1]);
  assign prod      = 64'(best_sec) * NS_PER_S + 64'(best_nsec);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      idx         <= '0;
      live        <= '0;
      now_q       <= '0;
      ser_ctr     <= '0;
      lim         <= '0;
      key_v1      <= 1'b0;
      key_type    <= '0;
      key_clkid   <= '0;
      key_port    <= '0;
      key_seq     <= '0;
      p1_go       <= 1'b0;
      p1_live     <= 1'b0;
      p1_idx      <= '0;
      best_found  <= 1'b0;
      best_idx    <= '0;
      best_ser    <= '0;
      best_sec    <= '0;
      best_nsec   <= '0;
      ins_err_o   <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_ns_o    <= '0;
    end else begin
      if (tick_i) now_q <= now_q + 1'b1;
      ins_err_o <= ins_valid_i && full;
      if (ins_ok) begin
        live[free_idx] <= 1'b1;
        ser_ctr        <= ser_ctr + 1'b1;
      end

      p1_go   <= (state == S_SCAN);
      p1_live <= live[idx];
      p1_idx  <= idx;
      if (p1_go && c_exp) live[p1_idx] <= 1'b0;
      if (take_best) begin
        best_found <= 1'b1;
        best_idx   <= p1_idx;
        best_ser   <= r_ser;
        best_sec   <= r_sec;
        best_nsec  <= r_nsec;
      end

      case (state)
        S_IDLE: begin
          if (lk_valid_i) begin
            key_v1     <= lk_v1_i;
            key_type   <= lk_type_i;
            key_clkid  <= lk_clkid_i;
            key_port   <= lk_port_i;
            key_seq    <= lk_seq_i;
            lim        <= ser_ctr;
            idx        <= '0;
            best_found <= 1'b0;
            state      <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (idx == AW'(DEPTH - 1)) state <= S_DRAIN;
          else idx <= idx + 1'b1;
        end
        S_DRAIN: state <= S_CALC;
        S_CALC: begin
          if (best_found) live[best_idx] <= 1'b0;
          rsp_valid_o <= 1'b1;
          rsp_hit_o   <= best_found;
          rsp_ns_o    <= best_found ? prod : 64'd0;
          state       <= S_RESP;
        end
        S_RESP: begin
          if (rsp_ready_i) begin
            rsp_valid_o <= 1'b0;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign lk_ready_o = (state == S_IDLE);

endmodule

// File: rtl/ptm_matcher_chk.sv
module ptm_matcher_chk #(
  parameter int DEPTH = 100
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic             rsp_hit_o,
  input logic [63:0]      rsp_ns_o,
  input logic             ins_valid_i,
  input logic             ins_err_o,
  input logic [DEPTH-1:0] live
);
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_ns_o) && $stable(rsp_hit_o)); // R10

  AST_NO_REQ_WHILE_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> !lk_ready_o); // R10

  AST_RSP_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid_o) |-> !$past(lk_ready_o)); // R10

  AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o && !rsp_hit_o |-> rsp_ns_o == 64'd0); // R6

  AST_ERR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    ins_err_o |-> $past(ins_valid_i) && ($past($countones(live)) == DEPTH)); // R8

  AST_ROOM_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    ins_valid_i && ($countones(live) < DEPTH) |=> !ins_err_o); // R8
endmodule

bind ptm_matcher ptm_matcher_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .lk_ready_o(lk_ready_o), .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i), .rsp_hit_o(rsp_hit_o), .rsp_ns_o(rsp_ns_o),
  .ins_valid_i(ins_valid_i), .ins_err_o(ins_err_o), .live(live)
);

// File: tb/tb_ptm_matcher.sv
module tb_ptm_matcher;
  localparam int DEPTH = 8;
  localparam int TICK_W = 8;
  localparam int AGE = 5;
  localparam int SER_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        tick = 0, ins_valid = 0, lk_valid = 0, lk_v1 = 0, rsp_ready = 0;
  logic [2:0]  ins_code = 0;
  logic [47:0] ins_sec = 0;
  logic [29:0] ins_nsec = 0;
  logic [63:0] ins_clkid = 0, lk_clkid = 0;
  logic [15:0] ins_port = 0, ins_seq = 0, lk_port = 0, lk_seq = 0;
  logic [3:0]  lk_type = 0;
  logic        ins_err, lk_ready, rsp_valid, rsp_hit;
  logic [63:0] rsp_ns;

  ptm_matcher #(.DEPTH(DEPTH), .TICK_W(TICK_W), .AGE_TICKS(AGE), .SER_W(SER_W)) dut (
    .clk(clk), .rst(rst), .tick_i(tick),
    .ins_valid_i(ins_valid), .ins_code_i(ins_code), .ins_sec_i(ins_sec),
    .ins_nsec_i(ins_nsec), .ins_clkid_i(ins_clkid), .ins_port_i(ins_port),
    .ins_seq_i(ins_seq), .ins_err_o(ins_err),
    .lk_valid_i(lk_valid), .lk_ready_o(lk_ready), .lk_v1_i(lk_v1),
    .lk_type_i(lk_type), .lk_clkid_i(lk_clkid), .lk_port_i(lk_port),
    .lk_seq_i(lk_seq), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_hit_o(rsp_hit), .rsp_ns_o(rsp_ns)
  );

  int tests = 0, fails = 0;
  string cur_req = "R1";

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic [2:0]  code;
    logic [63:0] ns;
    logic [63:0] clkid;
    logic [15:0] port;
    logic [15:0] seq;
    logic [7:0]  dl;
  } rec_t;
  rec_t q[$];
  logic [7:0] m_now;
  logic m_ready, m_rv, m_hit, m_err;
  logic [63:0] m_ns;
  int m_wait;

  function automatic logic [3:0] tmap(logic [2:0] c);
    if (c == 3'd1) return 4'd0;
    if (c == 3'd4) return 4'd1;
    if (c == 3'd2) return 4'd2;
    if (c == 3'd3) return 4'd3;
    return 4'hF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_now = 0; m_ready = 1; m_rv = 0; m_hit = 0; m_ns = 0;
      m_err = 0; m_wait = 0;
    end else begin
      automatic int sz = q.size();
      m_err = ins_valid && (sz == DEPTH);
      if (m_rv && rsp_ready) begin m_rv = 0; m_ready = 1; end
      if (m_wait > 0) begin
        m_wait--;
        if (m_wait == 0) m_rv = 1;
      end
      if (lk_valid && m_ready) begin
        automatic bit found = 0;
        automatic int i = 0;
        m_ready = 0; m_wait = DEPTH + 2; m_hit = 0; m_ns = 0;
        while (i < q.size()) begin
          automatic logic [7:0] d = m_now - q[i].dl;
          if (!d[7] && d != 0) q.delete(i);
          else if (!found && !lk_v1 && tmap(q[i].code) != 4'hF &&
                   tmap(q[i].code) == lk_type && q[i].clkid == lk_clkid &&
                   q[i].port == lk_port && q[i].seq == lk_seq) begin
            found = 1; m_hit = 1; m_ns = q[i].ns; q.delete(i);
          end else i++;
        end
      end
      if (ins_valid && sz < DEPTH) begin
        automatic rec_t r;
        r.code = ins_code; r.ns = 64'(ins_sec) * 64'd1000000000 + 64'(ins_nsec);
        r.clkid = ins_clkid; r.port = ins_port; r.seq = ins_seq;
        r.dl = m_now + 8'(AGE);
        q.push_back(r);
      end
      if (tick) m_now = m_now + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R10", {63'd0, lk_ready}, {63'd0, m_ready});
      chk("R10", {63'd0, rsp_valid}, {63'd0, m_rv});
      chk("R8", {63'd0, ins_err}, {63'd0, m_err});
      if (m_rv) begin
        chk(cur_req, {63'd0, rsp_hit}, {63'd0, m_hit});
        chk(cur_req, rsp_ns, m_ns);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_insert(logic [2:0] c, logic [47:0] s, logic [29:0] n,
                           logic [63:0] id, logic [15:0] p, logic [15:0] sq, bit exp_err);
    @(posedge clk); #1;
    ins_valid = 1; ins_code = c; ins_sec = s; ins_nsec = n;
    ins_clkid = id; ins_port = p; ins_seq = sq;
    @(posedge clk); #1;
    ins_valid = 0;
    @(negedge clk);
    chk("R8", {63'd0, ins_err}, {63'd0, exp_err});
  endtask

  task automatic do_tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1;
      @(posedge clk); #1 tick = 0;
    end
  endtask

  task automatic start_lookup(bit v1, logic [3:0] t, logic [63:0] id,
                              logic [15:0] p, logic [15:0] sq);
    @(posedge clk); #1;
    lk_valid = 1; lk_v1 = v1; lk_type = t; lk_clkid = id; lk_port = p; lk_seq = sq;
    @(posedge clk); #1;
    lk_valid = 0;
  endtask

  task automatic finish_lookup(string req, bit exp_hit, logic [63:0] exp_ns);
    automatic int n = 0;
    cur_req = req;
    @(negedge clk);
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    chk(req, {63'd0, rsp_hit}, {63'd0, exp_hit});
    chk(req, rsp_ns, exp_ns);
    chk("R10", {63'd0, lk_ready}, 64'd0);
    @(negedge clk); @(negedge clk);
    chk("R10", rsp_ns, exp_ns);
    @(posedge clk); #1 rsp_ready = 1;
    @(posedge clk); #1 rsp_ready = 0;
  endtask

  task automatic lookup(string req, bit v1, logic [3:0] t, logic [63:0] id,
                        logic [15:0] p, logic [15:0] sq, bit exp_hit, logic [63:0] exp_ns);
    start_lookup(v1, t, id, p, sq);
    finish_lookup(req, exp_hit, exp_ns);
  endtask

  localparam logic [63:0] CA = 64'h0011_2233_4455_6677;
  localparam logic [63:0] CB = 64'h8899_AABB_CCDD_EEFF;
  localparam logic [63:0] G  = 64'd1000000000;

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", {63'd0, lk_ready}, 64'd1);
    chk("R1", {63'd0, rsp_valid}, 64'd0);
    chk("R1", {63'd0, ins_err}, 64'd0);
    lookup("R1", 0, 4'd0, CA, 16'd1, 16'd10, 0, 64'd0);

    // R5: hit returns combined time, record released
    do_insert(3'd1, 48'd3, 30'd250, CA, 16'd1, 16'd10, 0);
    lookup("R5", 0, 4'd0, CA, 16'd1, 16'd10, 1, 3 * G + 250);
    lookup("R5", 0, 4'd0, CA, 16'd1, 16'd10, 0, 64'd0);

    // R2: tag code translation
    do_insert(3'd4, 48'd1, 30'd4, CA, 16'd1, 16'd11, 0);
    lookup("R2", 0, 4'd1, CA, 16'd1, 16'd11, 1, G + 4);
    do_insert(3'd2, 48'd1, 30'd2, CA, 16'd1, 16'd12, 0);
    lookup("R2", 0, 4'd2, CA, 16'd1, 16'd12, 1, G + 2);
    do_insert(3'd3, 48'd1, 30'd3, CA, 16'd1, 16'd13, 0);
    lookup("R2", 0, 4'd3, CA, 16'd1, 16'd13, 1, G + 3);
    do_insert(3'd5, 48'd1, 30'd5, CA, 16'd1, 16'd14, 0);
    lookup("R2", 0, 4'hF, CA, 16'd1, 16'd14, 0, 64'd0);
    do_insert(3'd0, 48'd1, 30'd6, CA, 16'd1, 16'd15, 0);
    lookup("R2", 0, 4'hF, CA, 16'd1, 16'd15, 0, 64'd0);

    // R3: every field must agree (R6 miss value)
    do_insert(3'd1, 48'd7, 30'd7, CB, 16'd2, 16'd20, 0);
    lookup("R3", 0, 4'd0, CA, 16'd2, 16'd20, 0, 64'd0);
    lookup("R3", 0, 4'd0, CB, 16'd3, 16'd20, 0, 64'd0);
    lookup("R3", 0, 4'd0, CB, 16'd2, 16'd21, 0, 64'd0);
    lookup("R6", 0, 4'd2, CB, 16'd2, 16'd20, 0, 64'd0);
    lookup("R3", 0, 4'd0, CB, 16'd2, 16'd20, 1, 7 * G + 7);

    // R4: version 1 lookups never hit and leave the record
    do_insert(3'd1, 48'd9, 30'd1, CB, 16'd2, 16'd30, 0);
    lookup("R4", 1, 4'd0, CB, 16'd2, 16'd30, 0, 64'd0);
    lookup("R4", 0, 4'd0, CB, 16'd2, 16'd30, 1, 9 * G + 1);

    // R9: oldest matching record answers first
    do_insert(3'd1, 48'd1, 30'd0, CB, 16'd4, 16'd40, 0);
    do_insert(3'd1, 48'd2, 30'd0, CB, 16'd4, 16'd40, 0);
    lookup("R9", 0, 4'd0, CB, 16'd4, 16'd40, 1, G);
    lookup("R9", 0, 4'd0, CB, 16'd4, 16'd40, 1, 2 * G);

    // R11: record inserted during a scan is invisible to it
    start_lookup(0, 4'd0, CB, 16'd5, 16'd50);
    do_insert(3'd1, 48'd5, 30'd50, CB, 16'd5, 16'd50, 0);
    finish_lookup("R11", 0, 64'd0);
    lookup("R11", 0, 4'd0, CB, 16'd5, 16'd50, 1, 5 * G + 50);

    // R7: age boundary
    do_insert(3'd1, 48'd6, 30'd60, CB, 16'd6, 16'd60, 0);
    do_tick(AGE);
    lookup("R7", 0, 4'd0, CB, 16'd6, 16'd60, 1, 6 * G + 60);
    do_insert(3'd1, 48'd6, 30'd61, CB, 16'd6, 16'd61, 0);
    do_tick(AGE + 1);
    lookup("R7", 0, 4'd0, CB, 16'd6, 16'd61, 0, 64'd0);

    // R8: capacity, dropped insert
    do_tick(AGE + 1);
    lookup("R7", 0, 4'd0, CA, 16'd9, 16'd9, 0, 64'd0);
    for (int k = 0; k < DEPTH; k++)
      do_insert(3'd1, 48'(k + 1), 30'd0, CA, 16'd7, 16'(100 + k), 0);
    do_insert(3'd1, 48'd99, 30'd0, CA, 16'd7, 16'd200, 1);
    lookup("R8", 0, 4'd0, CA, 16'd7, 16'd200, 0, 64'd0);
    lookup("R8", 0, 4'd0, CA, 16'd7, 16'd100, 1, G);
    do_insert(3'd1, 48'd50, 30'd0, CA, 16'd7, 16'd201, 0);
    do_insert(3'd1, 48'd51, 30'd0, CA, 16'd7, 16'd202, 1);
    // R7: expired slots are released by the next scan
    do_tick(AGE + 1);
    lookup("R7", 0, 4'd0, CA, 16'd7, 16'd101, 0, 64'd0);
    for (int k = 0; k < DEPTH; k++)
      do_insert(3'd1, 48'd1, 30'(k), CA, 16'd8, 16'(300 + k), 0);
    do_tick(AGE + 1);
    lookup("R7", 0, 4'd0, CA, 16'd9, 16'd9, 0, 64'd0);

    // R12: deadline across the tick wrap
    do_tick(int'(8'd254 - m_now));
    do_insert(3'd1, 48'd12, 30'd70, CA, 16'd9, 16'd70, 0);
    do_insert(3'd1, 48'd12, 30'd71, CA, 16'd9, 16'd71, 0);
    do_tick(AGE);
    lookup("R12", 0, 4'd0, CA, 16'd9, 16'd70, 1, 12 * G + 70);
    do_tick(1);
    lookup("R12", 0, 4'd0, CA, 16'd9, 16'd71, 0, 64'd0);

    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule